// File: doc/BRIEF.md
# Locked Bus Cycle Controller

This block sits between a processor's bus-cycle sequencer and a local bus that other masters share. The sequencer offers one bus cycle at a time on a start strobe and says whether that cycle belongs to a locked run and whether it is the last one of that run. The block drives an active-low lock line that tells other masters they may not take the bus. While the lock line is low, the block also refuses their hold requests. This keeps a semaphore read and the write that follows it together, with no foreign cycle between them.

The block counts the cycles it has accepted and retires one on every rising edge where the ready input is low. It can run with one cycle in flight, or with address pipelining, where a second cycle may start before the first has completed. With pipelining, an unlocked cycle may already be under way when the final locked cycle completes. In that case the lock line stays low until that unlocked cycle also completes, so another master waits one extra bus cycle. Hold is granted only on an idle, unlocked bus. While hold is granted, the block reports busy so that the sequencer starts nothing.

Top module: `bus_lock_ctrl`

## Requirements
- R1: A cycle accepted on an edge (cycStart high while busy is low) with the lock flag set drives lockN low from that same edge onward.
- R2: Cycle kind codes 1 (exchange), 2 (descriptor update) and 3 (interrupt acknowledge) lock the cycle even when the explicit lock flag is low. Kind 0 with the flag low leaves lockN high.
- R3: lockN returns high on the edge where readyN is sampled low for the cycle marked last-locked, provided no other accepted cycle is still outstanding.
- R4: With pipelining, if an unlocked cycle is outstanding when the last locked cycle completes, lockN stays low until the edge where readyN is sampled low for that unlocked cycle.
- R5: holdAck rises only on an edge where holdReq is high, lockN is high, no cycle is outstanding and no cycle is accepted. A hold request made while lockN is low is not acknowledged.
- R6: While holdAck is high, busy is high and cycStart is ignored. A locked start offered then does not pull lockN low.
- R7: holdAck falls on the first edge where holdReq is sampled low.
- R8: busy is high when one cycle is outstanding with pipeEn low, or when two are outstanding with pipeEn high. A start offered while busy is not accepted.
- R9: After reset, lockN is high, holdAck is low and busy is low.
- R10: lockN stays low without a gap across every cycle of a locked run, including the edges between cycles, and also when a new locked run was pipelined behind the last cycle of the previous run.
- R11: When a locked cycle is accepted on the same edge that completes the last cycle of the previous locked run, lockN stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pipeEn | input | 1 | High allows a second cycle to start while the first is still in flight |
| cycStart | input | 1 | Sequencer requests a cycle start on this edge |
| cycLocked | input | 1 | Explicit lock request for the offered cycle |
| cycLastLocked | input | 1 | Offered cycle is the final one of its locked run |
| cycKind | input | 2 | 0 plain, 1 exchange, 2 descriptor update, 3 interrupt acknowledge |
| readyN | input | 1 | Active-low completion of the oldest outstanding cycle |
| holdReq | input | 1 | Another master asks for the bus |
| busy | output | 1 | Starts are refused this cycle |
| lockN | output | 1 | Active-low bus lock |
| holdAck | output | 1 | Bus handed to the other master |

## Verification
The stimulus includes a non-pipelined semaphore read and write with hold requested throughout. This separates a lock line that is held across the gap between the two cycles from one that drops early, and it shows when hold can be granted. Pipelined runs are driven in two forms: with an unlocked cycle queued behind the last locked one, and with a new locked run queued behind it. These separate the one-cycle lock extension from a premature release, and from a release that ignores the queued lock. Further cases cover a locked start on the same edge as the release, starts offered while busy or while hold is granted, and each cycle kind offered without the explicit flag. They show that arbitration waits for an empty, unlocked bus and that auto-locking depends only on the kind code.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_XCHG  = 2'd1,
    KIND_DESC  = 2'd2,
    KIND_INTA  = 2'd3
  } cycKind_e;

  typedef enum logic [1:0] {
    LK_FREE   = 2'd0,
    LK_HELD   = 2'd1,
    LK_EXTEND = 2'd2
  } lockState_e;

  typedef struct packed {
    logic push;
    logic pop;
    logic pushLocked;
    logic pushLast;
  } trackStrobe_t;

endpackage

// File: rtl/bus_lock_track.sv
module bus_lock_track
  import bus_lock_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  trackStrobe_t  strobe,
  output logic [CW-1:0] count,
  output logic          headLast,
  output logic          restLocked
);

  logic [DEPTH-1:0] lockedQ;
  logic [DEPTH-1:0] lastQ;
  logic [DEPTH-1:0] lockedNext;
  logic [DEPTH-1:0] lastNext;
  logic [CW-1:0]    wrIdx;
  logic [DEPTH-1:0] restHit;

  assign wrIdx = count - CW'(strobe.pop);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shiftLk;
    logic shiftLs;
    if (i == DEPTH - 1) begin : g_top
      assign shiftLk = 1'b0;
      assign shiftLs = 1'b0;
    end else begin : g_mid
      assign shiftLk = lockedQ[i+1];
      assign shiftLs = lastQ[i+1];
    end

    always_comb begin
      lockedNext[i] = strobe.pop ? shiftLk : lockedQ[i];
      lastNext[i]   = strobe.pop ? shiftLs : lastQ[i];
      if (strobe.push && (wrIdx == CW'(i))) begin
        lockedNext[i] = strobe.pushLocked;
        lastNext[i]   = strobe.pushLast;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockedQ[i] <= 1'b0;
        lastQ[i]   <= 1'b0;
      end else begin
        lockedQ[i] <= lockedNext[i];
        lastQ[i]   <= lastNext[i];
      end
    end

    if (i == 0) begin : g_head
      assign restHit[i] = 1'b0;
    end else begin : g_rest
      assign restHit[i] = lockedQ[i] && (CW'(i) < count);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      count <= count + CW'(strobe.push) - CW'(strobe.pop);
    end
  end

  assign headLast   = lastQ[0];
  assign restLocked = |restHit;

  // R8: the tracker never holds more cycles than it has slots
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R8: a cycle is retired only when one is outstanding
  a_r8_pop_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));

  // R8: a push into a full tracker must coincide with a retirement
  a_r8_push_has_room: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> ((count < CW'(DEPTH)) || strobe.pop));

endmodule

// File: rtl/bus_lock_fsm.sv
module bus_lock_fsm
  import bus_lock_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pipeEn,
  input  logic          cycStart,
  input  logic          cycLocked,
  input  logic          cycLastLocked,
  input  logic [1:0]    cycKind,
  input  logic          readyN,
  input  logic          holdReq,
  input  logic [CW-1:0] count,
  input  logic          headLast,
  input  logic          restLocked,
  output trackStrobe_t  strobe,
  output logic          busy,
  output logic          lockN,
  output logic          holdAck
);

  lockState_e lockState;
  lockState_e lockNext;
  logic       holdNext;
  logic [CW-1:0] maxOut;
  logic       accept;
  logic       wantLock;
  logic       done;
  logic       remaining;

  assign maxOut   = pipeEn ? CW'(DEPTH) : CW'(1);
  assign busy     = holdAck || (count >= maxOut);
  assign accept   = cycStart && !busy;
  assign wantLock = cycLocked || (cycKindE != KIND_PLAIN);
  assign done     = (count != '0) && !readyN;
  assign remaining = (count > CW'(1));

  cycKind_e cycKindE;
  assign cycKindE = cycKind_e'(cycKind);

  always_comb begin
    strobe.push       = accept;
    strobe.pop        = done;
    strobe.pushLocked = wantLock;
    strobe.pushLast   = wantLock && cycLastLocked;
  end

  always_comb begin
    lockNext = lockState;
    if (accept && wantLock) begin
      lockNext = LK_HELD;
    end else begin
      unique case (lockState)
        LK_HELD: begin
          if (done && headLast) begin
            if (restLocked)     lockNext = LK_HELD;
            else if (remaining) lockNext = LK_EXTEND;
            else                lockNext = LK_FREE;
          end
        end
        LK_EXTEND: if (done) lockNext = LK_FREE;
        default:   lockNext = LK_FREE;
      endcase
    end
  end

  always_comb begin
    if (holdAck) begin
      holdNext = holdReq;
    end else begin
      holdNext = holdReq && (lockState == LK_FREE) && (count == '0) && !accept;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockState <= LK_FREE;
      holdAck   <= 1'b0;
    end else begin
      lockState <= lockNext;
      holdAck   <= holdNext;
    end
  end

  assign lockN = (lockState == LK_FREE);

  // R1: a locked start pulls the lock low from the edge it is accepted on
  a_r1_lock_on_start: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pushLocked) |=> !lockN);

  // R3: the lock is only released on an edge that retires a cycle
  a_r3_release_on_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockN) |-> $past(count != '0 && !readyN));

  // R5: hold is never acknowledged while the lock is low
  a_r5_no_ack_locked: assert property (@(posedge clk) disable iff (!rstN)
    !lockN |-> !holdAck);

  // R5: a grant only follows an idle, unlocked, requested bus
  a_r5_grant_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(lockN) && $past(count) == '0 && $past(holdReq)));

  // R6: nothing is pushed while the bus is handed over
  a_r6_no_start_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (busy && !strobe.push));

  // R7: a dropped request ends the grant on the next edge
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck && !holdReq) |=> !holdAck);

endmodule

// File: rtl/bus_lock_ctrl.sv
module bus_lock_ctrl
  import bus_lock_pkg::*;
#(
  parameter int PIPE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pipeEn,
  input  logic       cycStart,
  input  logic       cycLocked,
  input  logic       cycLastLocked,
  input  logic [1:0] cycKind,
  input  logic       readyN,
  input  logic       holdReq,
  output logic       busy,
  output logic       lockN,
  output logic       holdAck
);

  localparam int CW = $clog2(PIPE_DEPTH + 1);

  trackStrobe_t  strobe;
  logic [CW-1:0] count;
  logic          headLast;
  logic          restLocked;

  bus_lock_fsm #(.DEPTH(PIPE_DEPTH)) u_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .pipeEn        (pipeEn),
    .cycStart      (cycStart),
    .cycLocked     (cycLocked),
    .cycLastLocked (cycLastLocked),
    .cycKind       (cycKind),
    .readyN        (readyN),
    .holdReq       (holdReq),
    .count         (count),
    .headLast      (headLast),
    .restLocked    (restLocked),
    .strobe        (strobe),
    .busy          (busy),
    .lockN         (lockN),
    .holdAck       (holdAck)
  );

  bus_lock_track #(.DEPTH(PIPE_DEPTH)) u_track (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .count      (count),
    .headLast   (headLast),
    .restLocked (restLocked)
  );

endmodule

// File: tb/bus_lock_ctrl_test.sv
`timescale 1ns/1ps
module bus_lock_ctrl_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pipeEn = 1'b0;
  logic       cycStart = 1'b0;
  logic       cycLocked = 1'b0;
  logic       cycLastLocked = 1'b0;
  logic [1:0] cycKind = 2'd0;
  logic       readyN = 1'b1;
  logic       holdReq = 1'b0;
  logic       busy;
  logic       lockN;
  logic       holdAck;

  int checks = 0;
  int errors = 0;

  bit qLk[$];
  bit qLs[$];
  int mState = 0;
  bit mAck = 1'b0;

  always #10 clk = ~clk;

  bus_lock_ctrl uut (
    .clk(clk), .rstN(rstN), .pipeEn(pipeEn), .cycStart(cycStart),
    .cycLocked(cycLocked), .cycLastLocked(cycLastLocked), .cycKind(cycKind),
    .readyN(readyN), .holdReq(holdReq), .busy(busy), .lockN(lockN),
    .holdAck(holdAck)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic t(input bit s, input bit lk, input bit ls, input logic [1:0] k,
                   input bit r, input bit h, input string tag);
    bit expBusy, acc, lockedIn, dn, hl, rl, nAck;
    int rem, nState;
    cycStart = s; cycLocked = lk; cycLastLocked = ls; cycKind = k;
    readyN = r; holdReq = h;
    #1;
    expBusy = mAck || (qLk.size() >= (pipeEn ? 2 : 1));
    chk(tag, "busy", busy, expBusy);
    acc = s && !expBusy;
    lockedIn = lk || (k != 2'd0);
    dn = (qLk.size() > 0) && !r;
    if (mAck) nAck = h;
    else nAck = h && (mState == 0) && (qLk.size() == 0) && !acc;
    hl = 1'b0; rl = 1'b0; rem = 0;
    if (dn) begin
      hl = qLs[0];
      void'(qLk.pop_front());
      void'(qLs.pop_front());
      foreach (qLk[i]) if (qLk[i]) rl = 1'b1;
      rem = qLk.size();
    end
    nState = mState;
    if (acc && lockedIn) nState = 1;
    else if (mState == 1 && dn && hl) nState = rl ? 1 : (rem > 0 ? 2 : 0);
    else if (mState == 2 && dn) nState = 0;
    if (acc) begin
      qLk.push_back(lockedIn);
      qLs.push_back(lockedIn && ls);
    end
    @(posedge clk);
    mState = nState;
    mAck = nAck;
    @(negedge clk);
    chk(tag, "lockN", lockN, (mState == 0));
    chk(tag, "holdAck", holdAck, mAck);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    chk("R9", "lockN", lockN, 1'b1);
    chk("R9", "holdAck", holdAck, 1'b0);
    chk("R9", "busy", busy, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    // Non-pipelined semaphore read then write, hold requested throughout
    pipeEn = 1'b0;
    t(1, 1, 0, 0, 1, 1, "R1");
    t(1, 0, 0, 0, 1, 1, "R8");
    t(0, 0, 0, 0, 0, 1, "R10");
    t(1, 1, 1, 0, 1, 1, "R10");
    t(0, 0, 0, 0, 0, 1, "R3");
    t(0, 0, 0, 0, 1, 1, "R5");
    t(1, 1, 1, 1, 1, 1, "R6");
    t(1, 1, 0, 0, 1, 1, "R6");
    t(0, 0, 0, 0, 1, 0, "R7");
    t(0, 0, 0, 0, 1, 0, "R9");

    // Auto-lock cycle kinds without the explicit flag
    for (int k = 1; k < 4; k++) begin
      t(1, 0, 1, 2'(k), 1, 0, "R2");
      t(0, 0, 0, 0, 0, 0, "R2");
    end
    t(1, 0, 0, 0, 1, 0, "R2");
    t(0, 0, 0, 0, 0, 0, "R2");

    // Pipelined: unlocked cycle queued behind last locked cycle
    pipeEn = 1'b1;
    t(1, 1, 1, 0, 1, 1, "R4");
    t(1, 0, 0, 0, 1, 1, "R8");
    t(1, 1, 0, 0, 1, 1, "R8");
    t(0, 0, 0, 0, 0, 1, "R4");
    t(0, 0, 0, 0, 1, 1, "R4");
    t(0, 0, 0, 0, 0, 1, "R4");
    t(0, 0, 0, 0, 1, 1, "R5");
    t(0, 0, 0, 0, 1, 0, "R7");

    // Locked start on the release edge
    t(1, 1, 1, 2, 1, 0, "R11");
    t(1, 1, 1, 0, 0, 0, "R11");
    t(0, 0, 0, 0, 0, 1, "R3");
    // A start on the same edge blocks the grant
    t(1, 0, 0, 0, 1, 1, "R5");
    t(0, 0, 0, 0, 0, 1, "R5");
    t(0, 0, 0, 0, 1, 1, "R5");
    t(0, 0, 0, 0, 1, 0, "R7");

    // New locked run pipelined behind the end of the previous one
    t(1, 1, 1, 0, 1, 0, "R10");
    t(1, 1, 1, 0, 1, 1, "R10");
    t(0, 0, 0, 0, 0, 1, "R10");
    t(0, 0, 0, 0, 1, 1, "R10");
    t(0, 0, 0, 0, 0, 1, "R3");
    t(0, 0, 0, 0, 1, 1, "R5");
    t(0, 0, 0, 0, 1, 0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule